// File: doc/BRIEF.md
# Dual-Rail Supply Lockout Controller

This block decides when a gate driver may switch. It watches digitized readings of a positive gate supply and a negative hold-off supply, plus a local reference-good flag. It drives a single run-enable that is true only while every active monitor reports good. A PWM request reaches the gate output only while that enable holds.

The positive-rail turn-on threshold is programmable in millivolts and must lie in a legal range. Turn-off uses a fixed 1 V hysteresis below the turn-on threshold. A mode code picks the negative-rail target. The lockout threshold for that rail is four fifths of the target. Monitoring of the negative rail is off when that rail is grounded or supplied from outside.

A priority-coded status field names the condition that is currently holding the driver off. An enable for the on-chip negative-rail generator is also provided. Rail readings are signed millivolt samples, and the comparisons act only on a valid strobe.

Top module: `uvlo_guard`

## Requirements
- R1: With a legal threshold, a valid sample with `pos_mv` strictly greater than `on_thr_mv` sets the positive rail good.
- R2: A good positive rail is cleared only by a valid sample strictly below `on_thr_mv - 1000`. Samples from that level up to the threshold leave the state unchanged.
- R3: Rail readings presented while `sample_vld` is low have no effect on any monitor state.
- R4: Negative-rail targets by `neg_mode` are: 0 gives -8000 mV, 1 gives -5000 mV, 2 gives -3000 mV. The matching lockout thresholds are -6400, -4000 and -2400 mV. A valid sample at or below the threshold marks the rail good, and any other valid sample marks it bad.
- R5: `neg_mode` 3 (grounded rail) and codes 4 to 7 (external rail) disable negative monitoring, and the rail then counts as good.
- R6: `on_thr_mv` is legal only within 12000..22000 inclusive. While it is outside that range, `thr_err` is 1, and a valid sample clears the positive-rail good state.
- R7: `neggen_en` is 1 exactly when the last valid `pos_mv` exceeded 7500 and `neg_mode` is 0, 1 or 2.
- R8: `run_en` is 1 exactly when the positive rail is good, the threshold is legal, the negative rail is good and `ref_ok` is 1.
- R9: `fault_code` is 0 when running. Otherwise it is 1 for a positive-rail or threshold fault, else 2 for a negative-rail fault, else 3 for the reference, in that priority order.
- R10: `gate_out` is registered. It rises only on a clock after a 0-to-1 change of `pwm_in` seen while `run_en` is 1. It falls on the clock after `pwm_in` or `run_en` drops, and it does not restart until a fresh rising edge of `pwm_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sample_vld | input | 1 | Strobe marking a fresh pair of rail readings |
| pos_mv | input | 16 | Positive rail, signed millivolts |
| neg_mv | input | 16 | Negative rail, signed millivolts |
| on_thr_mv | input | 16 | Positive turn-on threshold, millivolts |
| neg_mode | input | 3 | Negative-rail target and monitoring mode |
| ref_ok | input | 1 | Local 5 V reference good |
| pwm_in | input | 1 | Requested gate state |
| run_en | output | 1 | All active monitors good |
| gate_out | output | 1 | Gated drive output |
| neggen_en | output | 1 | Permission for the on-chip negative-rail generator |
| thr_err | output | 1 | Programmed threshold out of range |
| fault_code | output | 2 | Priority-coded holding condition |

## Verification
The assertions assume that `pos_mv`, `neg_mv`, `on_thr_mv` and `neg_mode` change only between clock edges and are sampled as stable values on each edge. They also assume that `pwm_in` is low throughout reset, so the two-cycle look-back on the gate restart rule starts from a known level. The bench changes every input on the falling edge and holds `pwm_in` low until reset is released. It sweeps the rails, modes and threshold boundaries while keeping the threshold within 16 bits.

// File: rtl/uvlo_guard.sv
module uvlo_guard #(
  parameter int W         = 16,
  parameter int HYST_MV   = 1000,
  parameter int ON_MIN_MV = 12000,
  parameter int ON_MAX_MV = 22000,
  parameter int GEN_MV    = 7500
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sample_vld,
  input  logic signed [W-1:0] pos_mv,
  input  logic signed [W-1:0] neg_mv,
  input  logic        [W-1:0] on_thr_mv,
  input  logic        [2:0]   neg_mode,
  input  logic                ref_ok,
  input  logic                pwm_in,
  output logic                run_en,
  output logic                gate_out,
  output logic                neggen_en,
  output logic                thr_err,
  output logic        [1:0]   fault_code
);

  logic pos_ok_q, neg_ok_q, gen_q, pwm_d;
  logic neg_mon;
  int   neg_tgt, neg_thr, pos_i, on_i, off_i;

  assign pos_i   = int'(pos_mv);
  assign on_i    = int'(on_thr_mv);
  assign off_i   = on_i - HYST_MV;
  assign thr_err = (on_i < ON_MIN_MV) || (on_i > ON_MAX_MV);

  always_comb begin
    neg_mon = 1'b1;
    case (neg_mode)
      3'd0:    neg_tgt = -8000;
      3'd1:    neg_tgt = -5000;
      3'd2:    neg_tgt = -3000;
      default: begin neg_tgt = 0; neg_mon = 1'b0; end
    endcase
  end
  assign neg_thr = (neg_tgt * 4) / 5;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_ok_q <= 1'b0;
      neg_ok_q <= 1'b0;
      gen_q    <= 1'b0;
    end else if (sample_vld) begin
      if (thr_err)                   pos_ok_q <= 1'b0;
      else if (!pos_ok_q && pos_i > on_i) pos_ok_q <= 1'b1;
      else if (pos_ok_q && pos_i < off_i) pos_ok_q <= 1'b0;
      neg_ok_q <= int'(neg_mv) <= neg_thr;
      gen_q    <= pos_i > GEN_MV;
    end
  end

  logic pos_good, neg_good;
  assign pos_good  = pos_ok_q && !thr_err;
  assign neg_good  = !neg_mon || neg_ok_q;
  assign run_en    = pos_good && neg_good && ref_ok;
  assign neggen_en = gen_q && neg_mon;
  assign fault_code = !pos_good ? 2'd1 : !neg_good ? 2'd2 : !ref_ok ? 2'd3 : 2'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_d    <= 1'b0;
      gate_out <= 1'b0;
    end else begin
      pwm_d    <= pwm_in;
      gate_out <= run_en && pwm_in && (gate_out || !pwm_d);
    end
  end

endmodule

module uvlo_guard_chk #(
  parameter int W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                sample_vld,
  input logic signed [W-1:0] pos_mv,
  input logic        [W-1:0] on_thr_mv,
  input logic        [2:0]   neg_mode,
  input logic                ref_ok,
  input logic                pwm_in,
  input logic                run_en,
  input logic                gate_out,
  input logic                neggen_en,
  input logic                thr_err,
  input logic        [1:0]   fault_code,
  input logic                pos_ok_q
);

  a_r3_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_vld |=> $stable(pos_ok_q));

  a_r2_hysteresis_band: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_vld && pos_ok_q && !thr_err && (int'(pos_mv) >= int'(on_thr_mv) - 1000)) |=> pos_ok_q);

  a_r6_illegal_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    thr_err |-> !run_en && fault_code == 2'd1);

  a_r5_disabled_monitor: assert property (@(posedge clk) disable iff (!rst_n)
    (neg_mode >= 3'd3 && pos_ok_q && !thr_err && ref_ok) |-> run_en);

  a_r7_gen_mode: assert property (@(posedge clk) disable iff (!rst_n)
    neggen_en |-> neg_mode <= 3'd2);

  a_r9_code_matches_run: assert property (@(posedge clk) disable iff (!rst_n)
    run_en == (fault_code == 2'd0));

  a_r10_gate_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    gate_out |-> $past(run_en) && $past(pwm_in));

  a_r10_fresh_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_out) |-> !$past(pwm_in, 2));

endmodule

bind uvlo_guard uvlo_guard_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld), .pos_mv(pos_mv),
  .on_thr_mv(on_thr_mv), .neg_mode(neg_mode), .ref_ok(ref_ok), .pwm_in(pwm_in),
  .run_en(run_en), .gate_out(gate_out), .neggen_en(neggen_en), .thr_err(thr_err),
  .fault_code(fault_code), .pos_ok_q(pos_ok_q)
);

// File: tb/uvlo_guard_bench.sv
module uvlo_guard_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_vld = 1'b0;
  logic signed [15:0] pos_mv = '0;
  logic signed [15:0] neg_mv = '0;
  logic [15:0] on_thr_mv = 16'd15000;
  logic [2:0]  neg_mode = 3'd1;
  logic ref_ok = 1'b1;
  logic pwm_in = 1'b0;
  logic run_en, gate_out, neggen_en, thr_err;
  logic [1:0] fault_code;

  int checks = 0;
  int fails = 0;
  bit model_pos = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uvlo_guard u_uvlo_guard (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit legal(int t);
    return t >= 12000 && t <= 22000;
  endfunction

  task automatic smp(int p, int n);
    @(negedge clk);
    pos_mv = 16'(p); neg_mv = 16'(n); sample_vld = 1'b1;
    @(negedge clk);
    sample_vld = 1'b0;
    if (!legal(int'(on_thr_mv))) model_pos = 0;
    else if (!model_pos && p > int'(on_thr_mv)) model_pos = 1;
    else if (model_pos && p < int'(on_thr_mv) - 1000) model_pos = 0;
  endtask

  function automatic int nthr(int m);
    int tgt;
    tgt = (m == 0) ? -8000 : (m == 1) ? -5000 : -3000;
    return (tgt * 4) / 5;
  endfunction

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset run_en", run_en, 0);
    chk("R10 reset gate", gate_out, 0);
    chk("R9 reset code", fault_code, 1);
    chk("R7 reset gen", neggen_en, 0);
    rst_n = 1'b1;

    for (int p = 0; p <= 20000; p += 500) begin
      smp(p, -6000);
      chk("R1 rising sweep run", run_en, int'(model_pos));
      chk("R7 gen rising", neggen_en, int'(p > 7500));
    end
    for (int p = 20000; p >= 0; p -= 250) begin
      smp(p, -6000);
      chk("R2 falling sweep run", run_en, int'(model_pos));
      chk("R7 gen falling", neggen_en, int'(p > 7500));
    end
    smp(15000, -6000);
    chk("R1 equal not enough", run_en, 0);
    smp(15001, -6000);
    chk("R1 just above", run_en, 1);
    smp(14000, -6000);
    chk("R2 at off level holds", run_en, 1);
    smp(13999, -6000);
    chk("R2 below off clears", run_en, 0);

    smp(18000, -6000);
    @(negedge clk);
    pos_mv = 16'sd0; neg_mv = 16'sd5000;
    repeat (4) @(negedge clk);
    chk("R3 no strobe keeps run", run_en, 1);
    chk("R3 no strobe keeps gen", neggen_en, 1);

    for (int m = 0; m < 8; m++) begin
      neg_mode = 3'(m);
      for (int k = 0; k < 9; k++) begin
        int n;
        bit ng;
        case (k)
          0: n = -9000; 1: n = -6400; 2: n = -6399; 3: n = -4000; 4: n = -3999;
          5: n = -2400; 6: n = -2399; 7: n = 0; default: n = 1000;
        endcase
        smp(18000, n);
        ng = (m >= 3) ? 1'b1 : (n <= nthr(m));
        if (m < 3) chk("R4 neg monitor", run_en, int'(ng));
        else chk("R5 monitor disabled", run_en, 1);
        chk("R9 neg code", fault_code, ng ? 0 : 2);
        chk("R7 gen by mode", neggen_en, int'(m < 3));
      end
    end

    neg_mode = 3'd1;
    for (int t = 11990; t <= 12010; t += 10) begin
      on_thr_mv = 16'(t);
      smp(0, -6000);
      smp(t + 1, -6000);
      chk("R6 low bound thr_err", thr_err, int'(!legal(t)));
      chk("R6 low bound run", run_en, int'(legal(t)));
    end
    for (int t = 21990; t <= 22010; t += 10) begin
      on_thr_mv = 16'(t);
      smp(0, -6000);
      smp(25000, -6000);
      chk("R6 high bound run", run_en, int'(legal(t)));
      chk("R9 thr code", fault_code, legal(t) ? 0 : 1);
    end

    on_thr_mv = 16'd15000;
    smp(18000, -6000);
    @(negedge clk); ref_ok = 1'b0;
    #1;
    chk("R8 ref drops run", run_en, 0);
    chk("R9 ref code", fault_code, 3);
    smp(18000, 0);
    chk("R9 neg before ref", fault_code, 2);
    smp(0, 0);
    chk("R9 pos first", fault_code, 1);
    ref_ok = 1'b1;
    smp(18000, -6000);
    chk("R8 all good", run_en, 1);

    @(negedge clk); pwm_in = 1'b1;
    @(negedge clk);
    chk("R10 pulse starts", gate_out, 1);
    ref_ok = 1'b0;
    @(negedge clk);
    chk("R10 lockout ends pulse", gate_out, 0);
    ref_ok = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 no restart while high", gate_out, 0);
    pwm_in = 1'b0;
    @(negedge clk);
    chk("R10 low stays low", gate_out, 0);
    pwm_in = 1'b1;
    @(negedge clk);
    chk("R10 fresh edge restarts", gate_out, 1);
    pwm_in = 1'b0;
    @(negedge clk);
    chk("R10 pwm fall ends", gate_out, 0);
    ref_ok = 1'b0; pwm_in = 1'b1;
    @(negedge clk);
    chk("R10 edge during lockout", gate_out, 0);
    ref_ok = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 edge lost after lockout", gate_out, 0);
    pwm_in = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule